// File: doc/BRIEF.md
# Store-Multiple Word Sequencer

This block walks a run of general-purpose registers and turns them into a stream of 32-bit memory writes. A single start pulse carries the first register index, a base value with a flag that forces the base to zero, and a signed displacement. The sequencer forms the starting address from these inputs. It then steps the register index upward, one register at a time, until it reaches register 31, and writes the low 32 bits of each register to consecutive word addresses. The number of words is therefore fixed by the first index: starting at index s stores 32 - s words.

Register values come back on a combinational register-file read port that the block addresses with its own read index. Writes leave on a valid/ready channel. While `wr_valid_o` is high and `wr_ready_i` is low, the address, data and read index are held, and the sequence moves on only on a cycle where both are high. Valid never drops once raised until that word is taken. The operation is allowed only in big-endian mode. A start that arrives while the little-endian flag is set issues no write and raises a one-cycle alignment-error pulse instead.

Top module: `mw_store_seq`

## Requirements
- R1: The first write address equals the base (or 0 when `base_zero_i` is 1) plus the displacement sign-extended from 16 bits, taken modulo 2^32.
- R2: A run started at index s issues exactly 32 - s writes, with read indices s, s+1, ..., 31 in that order.
- R3: Each write carries bits [31:0] of `rf_data_i` for the read index presented with that write.
- R4: Each accepted write advances the next write address by 4.
- R5: While `wr_valid_o` is 1 and `wr_ready_i` is 0, on the next cycle `wr_valid_o` stays 1 and the address and read index are unchanged.
- R6: A start sampled with `little_endian_i` = 1 issues no write, leaves `busy_o` at 0, and drives `align_err_o` to 1 for exactly the next cycle.
- R7: `busy_o` is 1 from the cycle after an accepted start until the cycle in which the write for register 31 is accepted.
- R8: `done_o` is 1 for exactly one cycle, the cycle after the write for register 31 is accepted, and `busy_o` is 0 in that cycle.
- R9: A start that arrives while `busy_o` is 1 or `done_o` is 1 has no effect on the writes or on the state that follows.
- R10: After reset `busy_o`, `wr_valid_o`, `done_o` and `align_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| first_reg_i | input | 5 | Index of the first register to store |
| base_i | input | 32 | Base address value |
| base_zero_i | input | 1 | 1 = use zero instead of `base_i` |
| disp_i | input | 16 | Signed displacement |
| little_endian_i | input | 1 | 1 = little-endian mode, run refused |
| rf_idx_o | output | 5 | Register-file read index |
| rf_data_i | input | 64 | Register-file read data for `rf_idx_o` |
| wr_valid_o | output | 1 | A write word is offered |
| wr_ready_i | input | 1 | Memory accepts the offered word |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run-complete pulse |
| align_err_o | output | 1 | One-cycle alignment-error pulse |

## Verification
The bench starts runs at index 31, 29, 28 and 0 so that the single-word run, short runs and the full 32-word run are all covered. A design that counted the words wrong or stopped at 30 would log too few or too many writes. It uses a negative displacement together with the base-forced-to-zero flag, which catches a missing sign extension or a base that is never forced to zero. Ready is driven three ways: held high, toggled, and from an LFSR. A design that advanced on a stalled cycle would skip an address or drop a register. Further starts arrive in the middle of a run and on the done cycle; a design that honoured them would restart or add extra writes. A little-endian start checks that the error pulse lasts one cycle and that no stray write appears.

// File: rtl/mw_store_pkg.sv
package mw_store_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/mw_ea_calc.sv
module mw_ea_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;

  assign base_eff = base_zero_i ? '0 : base_i;

  generate
    if (DISP_W < ADDR_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign ea_o = base_eff + disp_ext;

endmodule

// File: rtl/mw_walker.sv
module mw_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREG   = 32,
  parameter int unsigned STEP_B = 4,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NREG - 1);
  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP_B);

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      idx_q  <= load_idx_i;
      addr_q <= load_addr_i;
    end else if (step_i && (idx_q != LAST_IDX)) begin
      idx_q  <= idx_q + IDX_W'(1);
      addr_q <= addr_q + ADDR_INC;
    end
  end

  assign idx_o  = idx_q;
  assign addr_o = addr_q;
  assign last_o = (idx_q == LAST_IDX);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_o && !load_i) |=> (addr_o == $past(addr_o) + ADDR_INC)) // R4
    else $error("address did not advance by one word");

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_o && !load_i) |=> (idx_o == $past(idx_o) + IDX_W'(1))) // R2
    else $error("index did not advance by one");

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> ($stable(idx_o) && $stable(addr_o))) // R5
    else $error("walker moved without a step");

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_store_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       little_endian_i,
  input  logic       wr_ready_i,
  input  logic       last_i,
  output logic       load_o,
  output logic       step_o,
  output logic       wr_valid_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       align_err_o
);

  seq_state_e state_q, state_d;
  logic       err_q;
  logic       idle;
  logic       accept_start;
  logic       refuse_start;

  assign idle         = (state_q == SEQ_IDLE);
  assign accept_start = idle && start_i && !little_endian_i;
  assign refuse_start = idle && start_i &&  little_endian_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept_start) state_d = SEQ_RUN;
      SEQ_RUN:  if (wr_ready_i && last_i) state_d = SEQ_DONE;
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= refuse_start;
    end
  end

  assign load_o      = accept_start;
  assign wr_valid_o  = (state_q == SEQ_RUN);
  assign step_o      = wr_valid_o && wr_ready_i;
  assign busy_o      = (state_q == SEQ_RUN);
  assign done_o      = (state_q == SEQ_DONE);
  assign align_err_o = err_q;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |=> !align_err_o) // R6
    else $error("alignment error longer than one cycle");

  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && little_endian_i && !busy_o && !done_o) |=> !busy_o) // R6
    else $error("little-endian start began a run");

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_o) |=> busy_o) // R9
    else $error("run ended without a final handshake");

endmodule

// File: rtl/mw_store_seq.sv
module mw_store_seq
  import mw_store_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned REG_W  = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NREG   = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  first_reg_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              little_endian_i,
  output logic [IDX_W-1:0]  rf_idx_o,
  input  logic [REG_W-1:0]  rf_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              align_err_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  logic [ADDR_W-1:0] ea_w;
  logic              load_w;
  logic              step_w;
  logic              last_w;
  logic [IDX_W-1:0]  idx_w;
  logic [ADDR_W-1:0] addr_w;

  mw_ea_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_ea (
    .base_i      (base_i),
    .base_zero_i (base_zero_i),
    .disp_i      (disp_i),
    .ea_o        (ea_w)
  );

  mw_walker #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .STEP_B (WORD_BYTES)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .load_idx_i  (first_reg_i),
    .load_addr_i (ea_w),
    .step_i      (step_w),
    .idx_o       (idx_w),
    .addr_o      (addr_w),
    .last_o      (last_w)
  );

  mw_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .little_endian_i (little_endian_i),
    .wr_ready_i      (wr_ready_i),
    .last_i          (last_w),
    .load_o          (load_w),
    .step_o          (step_w),
    .wr_valid_o      (wr_valid_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .align_err_o     (align_err_o)
  );

  generate
    if (REG_W > WORD_W) begin : g_low_slice
      assign wr_data_o = rf_data_i[WORD_W-1:0];
    end else begin : g_full
      assign wr_data_o = WORD_W'(rf_data_i);
    end
  endgenerate

  assign rf_idx_o  = idx_w;
  assign wr_addr_o = addr_w;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(rf_idx_o))) // R5
    else $error("offered write changed before acceptance");

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (wr_addr_o == $past(ea_w) && rf_idx_o == $past(first_reg_i))) // R1
    else $error("first address or index wrong");

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && rf_idx_o == LAST_IDX) |=> (done_o && !busy_o)) // R8
    else $error("no done after final word");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) // R8
    else $error("done longer than one cycle");

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> !wr_valid_o) // R6
    else $error("write issued alongside alignment error");

endmodule

// File: tb/sim_mw_store_seq.sv
`timescale 1ns/1ps
module sim_mw_store_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  first_reg_i = '0;
  logic [31:0] base_i = '0;
  logic        base_zero_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic        little_endian_i = 1'b0;
  logic [4:0]  rf_idx_o;
  logic [63:0] rf_data_i;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b1;
  logic [31:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o;
  logic        done_o;
  logic        align_err_o;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] log_addr [512];
  logic [31:0] log_data [512];
  logic [4:0]  log_idx  [512];
  int          log_n = 0;
  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr;
  logic [4:0]  hold_idx;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] regval(input logic [4:0] i);
    return {32'hC0DE_0000 | 32'(i), 32'h1357_0000 + 32'(i) * 32'h0001_0203};
  endfunction

  assign rf_data_i = regval(rf_idx_o);

  mw_store_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_reg_i(first_reg_i),
    .base_i(base_i), .base_zero_i(base_zero_i), .disp_i(disp_i),
    .little_endian_i(little_endian_i), .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .align_err_o(align_err_o)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready driver
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0: wr_ready_i = 1'b1;
        1: wr_ready_i = ~wr_ready_i;
        default: wr_ready_i = lfsr[0] | lfsr[3];
      endcase
    end
  end

  // handshake monitor and stall-hold check
  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(wr_valid_o && wr_addr_o == hold_addr && rf_idx_o == hold_idx, "R5",
            {27'd0, rf_idx_o, wr_addr_o}, {27'd0, hold_idx, hold_addr});
      end
      hold_pend = wr_valid_o && !wr_ready_i;
      hold_addr = wr_addr_o;
      hold_idx  = rf_idx_o;
      if (wr_valid_o && wr_ready_i && log_n < 512) begin
        log_addr[log_n] = wr_addr_o;
        log_data[log_n] = wr_data_o;
        log_idx[log_n]  = rf_idx_o;
        log_n++;
      end
    end
  end

  task automatic do_start(input logic [4:0] s, input logic [31:0] b, input logic bz,
                          input logic [15:0] d, input logic le);
    @(negedge clk);
    first_reg_i = s; base_i = b; base_zero_i = bz; disp_i = d; little_endian_i = le;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    little_endian_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_log(input int from, input logic [4:0] s, input logic [31:0] ea);
    int n = 32 - int'(s);
    chk(log_n - from == n, "R2", 64'(log_n - from), 64'(n));
    for (int k = 0; k < n && from + k < log_n; k++) begin
      logic [4:0]  ei = 5'(int'(s) + k);
      logic [31:0] ea_k = ea + 32'(4 * k);
      logic [63:0] rv = regval(ei);
      chk(log_idx[from+k] == ei, "R2", 64'(log_idx[from+k]), 64'(ei));
      chk(log_addr[from+k] == ea_k, (k == 0) ? "R1" : "R4", 64'(log_addr[from+k]), 64'(ea_k));
      chk(log_data[from+k] == rv[31:0], "R3", 64'(log_data[from+k]), 64'(rv[31:0]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy_o && !wr_valid_o && !done_o && !align_err_o, "R10",
        {60'd0, busy_o, wr_valid_o, done_o, align_err_o}, 64'd0);
  endtask

  task automatic t_run(input logic [4:0] s, input logic [31:0] b, input logic bz,
                       input logic [15:0] d, input int mode);
    int from;
    int cyc;
    logic [31:0] ea;
    rdy_mode = mode;
    ea = (bz ? 32'd0 : b) + {{16{d[15]}}, d};
    from = log_n;
    do_start(s, b, bz, d, 1'b0);
    chk(busy_o, "R7", 64'(busy_o), 64'd1);
    wait_done(cyc);
    chk(done_o && !busy_o, "R8", {62'd0, done_o, busy_o}, 64'd2);
    check_log(from, s, ea);
    @(negedge clk);
    chk(!done_o, "R8", 64'(done_o), 64'd0);
  endtask

  task automatic t_little_endian();
    int from = log_n;
    rdy_mode = 0;
    do_start(5'd10, 32'h100, 1'b0, 16'h0, 1'b1);
    chk(align_err_o && !busy_o, "R6", {62'd0, align_err_o, busy_o}, 64'd2);
    @(negedge clk);
    chk(!align_err_o && !busy_o, "R6", {62'd0, align_err_o, busy_o}, 64'd0);
    repeat (3) @(negedge clk);
    chk(log_n == from, "R6", 64'(log_n - from), 64'd0);
  endtask

  task automatic t_ignore_start();
    int from;
    int cyc;
    rdy_mode = 1;
    from = log_n;
    do_start(5'd28, 32'h0000_4000, 1'b0, 16'h0010, 1'b0);
    @(negedge clk);
    first_reg_i = 5'd3; base_i = 32'h9999_0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check_log(from, 5'd28, 32'h0000_4010);
    // start during the done cycle
    from = log_n;
    first_reg_i = 5'd30; base_i = 32'h7000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R9", 64'(busy_o), 64'd0);
    repeat (4) @(negedge clk);
    chk(log_n == from && !busy_o, "R9", 64'(log_n - from), 64'd0);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run(5'd31, 32'h0000_2000, 1'b0, 16'h0004, 0);
    t_run(5'd29, 32'h8000_1000, 1'b1, 16'hFFF8, 1);
    t_run(5'd0,  32'h1000_0000, 1'b0, 16'hFFFC, 2);
    t_run(5'd20, 32'hFFFF_FFF0, 1'b0, 16'h0008, 2);
    t_little_endian();
    t_ignore_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule